// File: doc/BRIEF.md
# Strip Event Parser

The strip event parser sits behind a silicon strip readout link. Each 18-bit link word holds two error flags and two bytes. The block walks an event grammar:

- an opening word carrying a sequence tag and a board tag;
- chip sections, each opened by a chip word with a zero low byte;
- strip words, each pairing a strip index with a pulse height;
- a closing word of two 0xC0 bytes.

For every strip word the block emits a 23-bit record to a downstream cluster stage. The pulse height in that record has been corrected through a per-strip gain/offset table. The closing word produces a summary record that carries the event tags and an error indication.

A test-select input switches the parser's source from the live link to an external test-data memory. That memory is addressed by an internal counter that steps once per consumed word.

The downstream side has a valid/ready handshake, and so does the live upstream side. When the output register is occupied and not drained, the parser stops accepting words. While it is stopped it holds every piece of parse state.

Top module: `strip_event_parser`

## Requirements
- R1: An input word splits into error flags in bits 17:16, a high byte in bits 15:8 and a low byte in bits 7:0. The first word of an event stores the high byte as the sequence tag and the low byte as the board tag, and it emits no record.
- R2: In the event body, a word whose high byte has bit 7 set and whose low byte is 0x00 opens a chip section. The chip number is the high byte's bits 3:0. The sequence tag resets the chip number to 0. A chip word emits no record.
- R3: A body word whose high byte has bit 7 clear is a strip word, with the strip index in high-byte bits 6:0. It emits a record laid out as follows:
  - bits 22:21 = 01 (type);
  - bit 20 = 1 only on the first strip after a chip word;
  - bit 19 = 0;
  - bits 18:11 = corrected pulse;
  - bits 10:7 = chip number;
  - bits 6:0 = strip index.
- R4: The table address output equals {chip number, strip index of the word now at the source}, 11 bits wide. It is presented in the cycle the word is offered, and the table entry is read back combinationally.
- R5: The pulse correction uses table entry bits 7:4 as G and bits 3:0 as O. The result is min(255, (max(pulse - O, 0) * (8 + G)) >> 3).
- R6: A body word whose two bytes are both 0xC0 closes the event and emits a record laid out as follows:
  - bits 22:21 = 10 (type);
  - bit 20 = 0;
  - bit 19 = 1;
  - bits 18:11 = sequence tag;
  - bits 10:3 = board tag;
  - bits 2:1 = 0;
  - bit 0 = event error.

  The next word is then taken as an opening word.
- R7: The event error is set by either of two conditions. The first is any nonzero error flag on any word from the opening word through the closing word. The second is a malformed body word: high-byte bit 7 set, low byte not 0x00, and not the closing pair. A malformed word is otherwise dropped. The event error is cleared by the next opening word.
- R8: With test_sel high, in_ready is 0 and words come from tmem_data at tmem_addr. The address advances by one per consumed word and wraps at the memory depth. With test_sel low, tmem_addr returns to 0 on the next cycle.
- R9: A word is consumed only when the output register is empty or being drained (in_ready = !out_valid || out_ready, gated by R8). While out_valid is high and out_ready is low, out_data holds steady and no word is lost.
- R10: After reset, out_valid is 0, tmem_addr is 0, and the parser expects an opening word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_sel | input | 1 | Selects the test-data memory as the word source |
| in_valid | input | 1 | Live word offered |
| in_word | input | 18 | Live link word |
| in_ready | output | 1 | Live word accepted this cycle when valid |
| tmem_addr | output | TMEM_AW | Test-data memory read address |
| tmem_data | input | 18 | Test-data memory word at tmem_addr |
| lut_addr | output | 11 | Gain/offset table address |
| lut_data | input | 8 | Gain/offset table entry at lut_addr |
| out_valid | output | 1 | Record valid |
| out_data | output | 23 | Strip or end-of-event record |
| out_ready | input | 1 | Downstream can take the record |

## Verification
Two functions can meet in one cycle.

- **Closing an event while raising its error.** A closing 0xC0 pair that itself carries error flags must close the event and also report the error in the same end record. The bench provokes this with exactly such a closing word and checks bit 0 of the record that follows.
- **Holding a record while the source changes.** Backpressure can coincide with a change of source. The bench toggles out_ready pseudo-randomly and flips test_sel mid-stream. A reference model then checks four things on every cycle: in_ready, tmem_addr, the held record, and that no word is dropped or repeated.

// File: rtl/spp_pkg.sv
package spp_pkg;
    localparam int BYTE_W  = 8;
    localparam int ERR_W   = 2;
    localparam int WORD_W  = ERR_W + 2 * BYTE_W;
    localparam int CHIP_W  = 4;
    localparam int STRIP_W = 7;
    localparam int LUT_AW  = CHIP_W + STRIP_W;
    localparam int TYPE_W  = 2;
    localparam int REC_W   = TYPE_W + 2 + BYTE_W + CHIP_W + STRIP_W;
    localparam logic [BYTE_W-1:0] CLOSE_BYTE = 8'hC0;
    localparam logic [TYPE_W-1:0] REC_STRIP  = 2'b01;
    localparam logic [TYPE_W-1:0] REC_CLOSE  = 2'b10;

    typedef enum logic [1:0] {
        WK_STRIP,
        WK_CHIP,
        WK_CLOSE,
        WK_BAD
    } word_kind_e;

    typedef enum logic {
        PS_OPEN,
        PS_BODY
    } parse_st_e;

    typedef struct packed {
        parse_st_e          st;
        logic [BYTE_W-1:0]  seq;
        logic [BYTE_W-1:0]  board;
        logic [CHIP_W-1:0]  chip;
        logic               first;
        logic               err;
        logic               ovalid;
        logic [REC_W-1:0]   odata;
    } pstate_t;
endpackage

// File: rtl/spp_word_source.sv
module spp_word_source
    import spp_pkg::*;
#(
    parameter int TMEM_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_sel,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    input  logic [WORD_W-1:0]  tmem_data,
    input  logic               take,
    output logic               src_valid,
    output logic [WORD_W-1:0]  src_word,
    output logic [TMEM_AW-1:0] tmem_addr
);
    logic [TMEM_AW-1:0] addr_d, addr_q;

    always_comb begin
        src_valid = test_sel | in_valid;
        src_word  = test_sel ? tmem_data : in_word;
        if (!test_sel) begin
            addr_d = '0;
        end else if (take) begin
            addr_d = addr_q + 1'b1;
        end else begin
            addr_d = addr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign tmem_addr = addr_q;
endmodule

// File: rtl/spp_word_classifier.sv
module spp_word_classifier
    import spp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_kind_e        kind,
    output logic              err_hit
);
    logic [BYTE_W-1:0] hi, lo;

    always_comb begin
        hi      = word[2*BYTE_W-1:BYTE_W];
        lo      = word[BYTE_W-1:0];
        err_hit = |word[WORD_W-1:2*BYTE_W];
        if (hi == CLOSE_BYTE && lo == CLOSE_BYTE) begin
            kind = WK_CLOSE;
        end else if (!hi[BYTE_W-1]) begin
            kind = WK_STRIP;
        end else if (lo == '0) begin
            kind = WK_CHIP;
        end else begin
            kind = WK_BAD;
        end
    end
endmodule

// File: rtl/spp_pulse_corrector.sv
module spp_pulse_corrector
    import spp_pkg::*;
#(
    parameter int GAIN_W  = 4,
    parameter int OFS_W   = 4,
    parameter int GAIN_SH = 3
) (
    input  logic [BYTE_W-1:0]       pulse,
    input  logic [GAIN_W+OFS_W-1:0] entry,
    output logic [BYTE_W-1:0]       corrected
);
    localparam int MUL_W  = GAIN_W + 1;
    localparam int PROD_W = BYTE_W + MUL_W;

    logic [OFS_W-1:0]  ofs;
    logic [MUL_W-1:0]  mul;
    logic [BYTE_W-1:0] diff;
    logic [PROD_W-1:0] prod, shifted;

    always_comb begin
        ofs  = entry[OFS_W-1:0];
        mul  = {1'b0, entry[GAIN_W+OFS_W-1:OFS_W]} + MUL_W'(1 << GAIN_SH);
        diff = (pulse > BYTE_W'(ofs)) ? (pulse - BYTE_W'(ofs)) : '0;
        prod = PROD_W'(diff) * PROD_W'(mul);
        shifted = prod >> GAIN_SH;
        if (shifted > PROD_W'({BYTE_W{1'b1}})) begin
            corrected = '1;
        end else begin
            corrected = shifted[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/strip_event_parser.sv
module strip_event_parser
    import spp_pkg::*;
#(
    parameter int TMEM_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_sel,
    input  logic               in_valid,
    input  logic [17:0]        in_word,
    output logic               in_ready,
    output logic [TMEM_AW-1:0] tmem_addr,
    input  logic [17:0]        tmem_data,
    output logic [10:0]        lut_addr,
    input  logic [7:0]         lut_data,
    output logic               out_valid,
    output logic [22:0]        out_data,
    input  logic               out_ready
);
    pstate_t           s_d, s_q;
    logic              ready, take, src_valid, err_hit;
    logic [WORD_W-1:0] src_word;
    logic [BYTE_W-1:0] hi, lo, corr;
    word_kind_e        kind;

    assign ready    = !s_q.ovalid || out_ready;
    assign take     = ready && src_valid;
    assign in_ready = ready && !test_sel;
    assign hi       = src_word[2*BYTE_W-1:BYTE_W];
    assign lo       = src_word[BYTE_W-1:0];
    assign lut_addr = {s_q.chip, hi[STRIP_W-1:0]};

    spp_word_source #(.TMEM_AW(TMEM_AW)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_sel  (test_sel),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .tmem_data (tmem_data),
        .take      (take),
        .src_valid (src_valid),
        .src_word  (src_word),
        .tmem_addr (tmem_addr)
    );

    spp_word_classifier u_cls (
        .word    (src_word),
        .kind    (kind),
        .err_hit (err_hit)
    );

    spp_pulse_corrector u_corr (
        .pulse     (lo),
        .entry     (lut_data),
        .corrected (corr)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.ovalid && out_ready) begin
            s_d.ovalid = 1'b0;
        end
        if (take) begin
            if (s_q.st == PS_OPEN) begin
                s_d.seq   = hi;
                s_d.board = lo;
                s_d.chip  = '0;
                s_d.first = 1'b0;
                s_d.err   = err_hit;
                s_d.st    = PS_BODY;
            end else begin
                unique case (kind)
                    WK_CHIP: begin
                        s_d.chip  = hi[CHIP_W-1:0];
                        s_d.first = 1'b1;
                        s_d.err   = s_q.err | err_hit;
                    end
                    WK_STRIP: begin
                        s_d.ovalid = 1'b1;
                        s_d.odata  = {REC_STRIP, s_q.first, 1'b0, corr,
                                      s_q.chip, hi[STRIP_W-1:0]};
                        s_d.first  = 1'b0;
                        s_d.err    = s_q.err | err_hit;
                    end
                    WK_CLOSE: begin
                        s_d.ovalid = 1'b1;
                        s_d.odata  = {REC_CLOSE, 1'b0, 1'b1, s_q.seq, s_q.board,
                                      2'b00, s_q.err | err_hit};
                        s_d.st     = PS_OPEN;
                    end
                    default: begin
                        s_d.err = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PS_OPEN, seq: '0, board: '0, chip: '0, first: 1'b0,
                     err: 1'b0, ovalid: 1'b0, odata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ovalid;
    assign out_data  = s_q.odata;
endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
    parameter int TMEM_AW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               test_sel,
    input logic               in_ready,
    input logic [TMEM_AW-1:0] tmem_addr,
    input logic               out_valid,
    input logic [22:0]        out_data,
    input logic               out_ready
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    assert_test_blocks_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_sel |-> !in_ready);

    assert_addr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_sel |=> tmem_addr == '0);

    assert_rec_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[22:21] == 2'b01 || out_data[22:21] == 2'b10));

    assert_close_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data[22:21] == 2'b10) == out_data[19]));

    assert_close_not_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data[19] |-> !out_data[20] && out_data[2:1] == 2'b00);
endmodule

bind strip_event_parser spp_checker #(.TMEM_AW(TMEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_sel  (test_sel),
    .in_ready  (in_ready),
    .tmem_addr (tmem_addr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/strip_event_parser_tb.sv
module strip_event_parser_tb;
    localparam int TAW   = 4;
    localparam int TDEP  = 1 << TAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           test_sel = 1'b0;
    logic           in_valid = 1'b0;
    logic [17:0]    in_word = '0;
    logic           in_ready;
    logic [TAW-1:0] tmem_addr;
    logic [17:0]    tmem_data;
    logic [10:0]    lut_addr;
    logic [7:0]     lut_data;
    logic           out_valid;
    logic [22:0]    out_data;
    logic           out_ready = 1'b1;

    logic [17:0] tmem [TDEP];
    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit stall_en = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int          m_st = 0;
    logic [7:0]  m_seq = 0, m_brd = 0;
    logic [3:0]  m_chip = 0;
    bit          m_first = 0, m_err = 0, m_ov = 0;
    logic [22:0] m_od = '0;
    int          m_ta = 0;

    strip_event_parser #(.TMEM_AW(TAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_sel(test_sel), .in_valid(in_valid),
        .in_word(in_word), .in_ready(in_ready), .tmem_addr(tmem_addr),
        .tmem_data(tmem_data), .lut_addr(lut_addr), .lut_data(lut_data),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] lut_f(input logic [10:0] a);
        return 8'((a * 37) ^ (a >> 2));
    endfunction

    assign lut_data  = lut_f(lut_addr);
    assign tmem_data = tmem[tmem_addr];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_word(input logic [17:0] w);
        logic [7:0] hi, lo, g, o;
        bit e;
        int d, c;
        hi = w[15:8]; lo = w[7:0]; e = (w[17:16] != 0);
        if (m_st == 0) begin
            m_seq = hi; m_brd = lo; m_chip = 0; m_first = 0; m_err = e; m_st = 1;
        end else if (hi == 8'hC0 && lo == 8'hC0) begin
            m_ov = 1;
            m_od = {2'b10, 1'b0, 1'b1, m_seq, m_brd, 2'b00, (m_err | e)};
            m_st = 0;
        end else if (hi[7] == 1'b0) begin
            g = {4'd0, lut_f({m_chip, hi[6:0]}) >> 4};
            o = {4'd0, lut_f({m_chip, hi[6:0]}) & 8'h0F};
            d = int'(lo) - int'(o);
            if (d < 0) d = 0;
            c = (d * (8 + int'(g))) / 8;
            if (c > 255) c = 255;
            m_ov = 1;
            m_od = {2'b01, m_first, 1'b0, 8'(c), m_chip, hi[6:0]};
            m_first = 0;
            m_err = m_err | e;
        end else if (lo == 8'h00) begin
            m_chip = hi[3:0]; m_first = 1; m_err = m_err | e;
        end else begin
            m_err = 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ov = 0; m_ta = 0; m_first = 0; m_err = 0; m_chip = 0;
        end else begin
            bit rdy, sv;
            logic [17:0] w;
            rdy = !m_ov || out_ready;
            sv  = test_sel ? 1'b1 : in_valid;
            w   = test_sel ? tmem[m_ta] : in_word;
            if (m_ov && out_ready) m_ov = 0;
            if (rdy && sv) model_word(w);
            if (!test_sel) m_ta = 0;
            else if (rdy) m_ta = (m_ta + 1) % TDEP;
        end
    end

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            logic [17:0] w;
            w = test_sel ? tmem[m_ta] : in_word;
            chk("R9 in_ready", 32'(in_ready), 32'((!m_ov || out_ready) && !test_sel));
            chk("R8 tmem_addr", 32'(tmem_addr), 32'(m_ta));
            chk("R1/R2 out_valid", 32'(out_valid), 32'(m_ov));
            if (m_ov) begin
                if (m_od[22:21] == 2'b01)
                    chk("R3/R5 strip record", 32'(out_data), 32'(m_od));
                else
                    chk("R6/R7 close record", 32'(out_data), 32'(m_od));
            end
            if (w[15] == 1'b0 && m_st == 1)
                chk("R4 lut_addr", 32'(lut_addr), 32'({m_chip, w[14:8]}));
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic send(input logic [17:0] w);
        in_word = w;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic event_a;
        send({2'b00, 8'hAA, 8'h77});
        send({2'b00, 8'h81, 8'h00});
        send({2'b00, 8'h6B, 8'h03});
        send({2'b00, 8'h6C, 8'h04});
        send({2'b00, 8'h82, 8'h00});
        send({2'b00, 8'h10, 8'hFF});
        send({2'b00, 8'h11, 8'h00});
        send({2'b00, 8'hC0, 8'hC0});
    endtask

    initial begin
        tmem[0]  = {2'b00, 8'h5A, 8'h01};
        tmem[1]  = {2'b00, 8'h83, 8'h00};
        tmem[2]  = {2'b00, 8'h05, 8'h80};
        tmem[3]  = {2'b00, 8'h06, 8'h10};
        tmem[4]  = {2'b00, 8'hC0, 8'hC0};
        tmem[5]  = {2'b00, 8'hBB, 8'h02};
        tmem[6]  = {2'b00, 8'h8F, 8'h00};
        tmem[7]  = {2'b00, 8'h7F, 8'hFF};
        tmem[8]  = {2'b10, 8'h01, 8'h02};
        tmem[9]  = {2'b00, 8'hC0, 8'hC0};
        tmem[10] = {2'b00, 8'h3C, 8'h04};
        tmem[11] = {2'b00, 8'h84, 8'h00};
        tmem[12] = {2'b00, 8'h22, 8'h33};
        tmem[13] = {2'b00, 8'h90, 8'h55};
        tmem[14] = {2'b00, 8'h23, 8'h00};
        tmem[15] = {2'b00, 8'hC0, 8'hC0};

        idle(2);
        @(negedge clk);
        chk("R10 reset out_valid", 32'(out_valid), 32'd0);
        chk("R10 reset tmem_addr", 32'(tmem_addr), 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // live event, no backpressure
        event_a();
        idle(3);
        // same event under backpressure with gaps
        stall_en = 1;
        event_a();
        idle(2);
        // R7: error flags on strip, malformed word, error on close word
        send({2'b00, 8'hAB, 8'h01});
        send({2'b00, 8'h85, 8'h00});
        send({2'b01, 8'h20, 8'h40});
        send({2'b00, 8'hC0, 8'hC0});
        send({2'b00, 8'hAC, 8'h02});
        send({2'b00, 8'h86, 8'h00});
        send({2'b00, 8'h9A, 8'h12});
        send({2'b00, 8'h21, 8'h09});
        send({2'b00, 8'hC0, 8'hC0});
        send({2'b00, 8'hAD, 8'h03});
        send({2'b11, 8'hC0, 8'hC0});
        // clean event after errors: flag cleared at opening word
        send({2'b00, 8'hAE, 8'h04});
        send({2'b00, 8'h00, 8'h00});
        send({2'b00, 8'hC0, 8'hC0});
        idle(3);
        // R8: test source, long enough to wrap under backpressure
        @(posedge clk); #1;
        test_sel = 1'b1;
        in_valid = 1'b1;
        in_word = {2'b00, 8'h99, 8'h99};
        idle(60);
        test_sel = 1'b0;
        in_valid = 1'b0;
        idle(3);
        // live again, full-speed
        stall_en = 0;
        send({2'b00, 8'hC0, 8'hC0});
        event_a();
        idle(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule